// File: doc/BRIEF.md
# Load Dependency Tracking Table

This block watches a stream of retired instructions, one per cycle, and finds pointer-chasing links between loads. A load is linked to an earlier load when the earlier load produced the value in the register that the later load uses as its address base. For every link it finds, the block emits one record: the instruction address of the producing load, the instruction address of the consuming load, and the consumer's immediate offset. A stream of these records describes a linked structure as a chain of offsets, and a later stage can compress or replay that chain.

Producers are kept in a table with one entry per architectural register. Pointers that are spilled to memory and reloaded are followed through a small fully associative spill table. Each entry in the spill table holds a store's effective address and the instruction address of the load whose value was stored. Records leave through a single valid/ready slot. When that slot is blocked, the input stalls.

Top module: `load_dep_tracker`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Every register and spill entry is empty, so no load emits a record until a producer has been installed.
- R2: An accepted load (`in_op` = 1) whose base register holds a valid producer emits a record in the next cycle, carrying the producer PC, the load's own PC and the load's `in_off`.
- R3: An accepted load with a nonzero destination installs itself as that register's producer. A load whose base register is also its destination looks up the old producer first and installs itself afterwards.
- R4: An accepted load whose base register has no valid producer emits no record.
- R5: Register 0 never holds a producer. A load that writes register 0 installs nothing, and a later load based on register 0 emits no record.
- R6: An accepted instruction of the other register-writing class (`in_op` = 3) invalidates the producer entry of its destination register.
- R7: A store (`in_op` = 2) whose data register (`in_dst`) holds a valid producer records that producer against the store's `in_addr`. A later load from that address installs the recorded producer into its destination in place of itself.
- R8: A store whose data register has no valid producer removes any spill entry at its address. A later load from that address then installs itself.
- R9: The spill table has 16 entries filled in round-robin order. A store that hits an existing address updates that entry in place. The 17th distinct address evicts the oldest entry.
- R10: Producer entries survive any number of unrelated instructions that do not write their register (tested with 50 such loads).
- R11: While `out_valid` is 1 and `out_ready` is 0, the record holds still and `in_ready` is 0. Records leave in acceptance order and none is lost. Opcode value 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | The instruction is accepted this cycle |
| in_op | input | 2 | Class: 0 none, 1 load, 2 store, 3 other register write |
| in_pc | input | PC_W | Instruction address |
| in_dst | input | log2(NREG) | Load/write destination, or store data register |
| in_base | input | log2(NREG) | Address base register |
| in_off | input | OFF_W | Immediate offset |
| in_addr | input | ADDR_W | Effective address |
| out_valid | output | 1 | A dependency record is presented |
| out_ready | input | 1 | The record is taken this cycle |
| out_prod_pc | output | PC_W | Producer load address |
| out_cons_pc | output | PC_W | Consumer load address |
| out_off | output | OFF_W | Consumer immediate offset |

## Verification
Two things can happen in the same accepted cycle for one instruction: the producer table is read for the base register, and the same register is written as the destination. The bench triggers this with a repeated load whose base and destination are the same register. It expects each record to name the previous producer and not the instruction itself. A second overlap is a record leaving the output slot in the same cycle that a new one is pushed. This is triggered by releasing a held output while a second dependent load is waiting. The scoreboard then has to see both records, in order.

// File: rtl/ldt_pkg.sv
package ldt_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_WRITE = 2'd3
    } op_e;

endpackage

// File: rtl/ldt_prod_table.sv
module ldt_prod_table #(
    parameter int NREG = 32,
    parameter int PC_W = 32,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   rd_idx,
    output logic            rd_hit,
    output logic [PC_W-1:0] rd_pc,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic            wr_set,
    input  logic [PC_W-1:0] wr_pc
);

    typedef struct packed {
        logic [NREG-1:0]           vld;
        logic [NREG-1:0][PC_W-1:0] pc;
    } prod_st_t;

    prod_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[wr_idx] = wr_set;
            if (wr_set) begin
                st_d.pc[wr_idx] = wr_pc;
            end
        end
        rd_hit = st_q.vld[rd_idx];
        rd_pc  = st_q.pc[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: the zero register never gains a producer
    a_r5_zero_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld[0]);

    // R3: an installed producer is readable from the following cycle
    a_r3_install: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_set) |=> (st_q.vld[$past(wr_idx)] && st_q.pc[$past(wr_idx)] == $past(wr_pc)));

endmodule

// File: rtl/ldt_spill_table.sv
module ldt_spill_table #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int PC_W   = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [PC_W-1:0]   lk_pc,
    input  logic              upd_en,
    input  logic              upd_set,
    input  logic [PC_W-1:0]   upd_pc
);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][PC_W-1:0]   pc;
        logic [PW-1:0]                ptr;
    } spill_st_t;

    spill_st_t        st_d, st_q;
    logic [DEPTH-1:0] match;
    logic [PW-1:0]    hit_idx;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = st_q.vld[g] && (st_q.addr[g] == lk_addr);
        end
    endgenerate

    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx = PW'(i);
            end
        end
        lk_hit = |match;
        lk_pc  = st_q.pc[hit_idx];

        st_d = st_q;
        if (upd_en) begin
            if (upd_set) begin
                if (lk_hit) begin
                    st_d.pc[hit_idx] = upd_pc;
                end else begin
                    st_d.vld[st_q.ptr]  = 1'b1;
                    st_d.addr[st_q.ptr] = lk_addr;
                    st_d.pc[st_q.ptr]   = upd_pc;
                    st_d.ptr = (st_q.ptr == PW'(DEPTH - 1)) ? '0 : st_q.ptr + 1'b1;
                end
            end else if (lk_hit) begin
                st_d.vld[hit_idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: an address is never held by more than one entry
    a_r9_unique: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R9: an in-place update does not advance the replacement pointer
    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_set && lk_hit) |=> $stable(st_q.ptr));

endmodule

// File: rtl/ldt_out_slot.sv
module ldt_out_slot #(
    parameter int REC_W = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [REC_W-1:0] push_rec,
    output logic             can_take,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [REC_W-1:0] out_rec
);

    typedef struct packed {
        logic             vld;
        logic [REC_W-1:0] rec;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        can_take = !st_q.vld || out_ready;
        st_d     = st_q;
        if (push) begin
            st_d.vld = 1'b1;
            st_d.rec = push_rec;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
        out_valid = st_q.vld;
        out_rec   = st_q.rec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R11: a blocked record stays put
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rec)));

    // R11: nothing is pushed over a record that is still waiting
    a_r11_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!out_valid || out_ready));

endmodule

// File: rtl/load_dep_tracker.sv
module load_dep_tracker #(
    parameter int NREG        = 32,
    parameter int PC_W        = 32,
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 16,
    parameter int SPILL_DEPTH = 16,
    localparam int IW = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [IW-1:0]     in_dst,
    input  logic [IW-1:0]     in_base,
    input  logic [OFF_W-1:0]  in_off,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PC_W-1:0]   out_prod_pc,
    output logic [PC_W-1:0]   out_cons_pc,
    output logic [OFF_W-1:0]  out_off
);
    import ldt_pkg::*;

    localparam int REC_W = 2 * PC_W + OFF_W;

    op_e              op;
    logic             accept;
    logic [IW-1:0]    rd_idx;
    logic             rd_hit;
    logic [PC_W-1:0]  rd_pc;
    logic             wr_en;
    logic             wr_set;
    logic [PC_W-1:0]  wr_pc;
    logic             lk_hit;
    logic [PC_W-1:0]  lk_pc;
    logic             upd_en;
    logic             push;
    logic [REC_W-1:0] push_rec;
    logic [REC_W-1:0] out_rec;
    logic             can_take;

    always_comb begin
        op       = op_e'(in_op);
        in_ready = can_take;
        accept   = in_valid && can_take;
        rd_idx   = (op == OP_STORE) ? in_dst : in_base;

        push     = accept && (op == OP_LOAD) && rd_hit;
        push_rec = {rd_pc, in_pc, in_off};

        wr_en  = accept && ((op == OP_LOAD) || (op == OP_WRITE)) && (in_dst != '0);
        wr_set = (op == OP_LOAD);
        wr_pc  = lk_hit ? lk_pc : in_pc;

        upd_en = accept && (op == OP_STORE);

        out_prod_pc = out_rec[REC_W-1 -: PC_W];
        out_cons_pc = out_rec[OFF_W +: PC_W];
        out_off     = out_rec[OFF_W-1:0];
    end

    ldt_prod_table #(.NREG(NREG), .PC_W(PC_W)) u_prod (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (rd_idx),
        .rd_hit (rd_hit),
        .rd_pc  (rd_pc),
        .wr_en  (wr_en),
        .wr_idx (in_dst),
        .wr_set (wr_set),
        .wr_pc  (wr_pc)
    );

    ldt_spill_table #(.DEPTH(SPILL_DEPTH), .ADDR_W(ADDR_W), .PC_W(PC_W)) u_spill (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_addr (in_addr),
        .lk_hit  (lk_hit),
        .lk_pc   (lk_pc),
        .upd_en  (upd_en),
        .upd_set (rd_hit),
        .upd_pc  (rd_pc)
    );

    ldt_out_slot #(.REC_W(REC_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_rec  (push_rec),
        .can_take  (can_take),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_rec   (out_rec)
    );

    // R11: input stalls while the output is blocked
    a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R2: a load with a known producer shows up at the output next cycle
    a_r2_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_LOAD && rd_hit) |=>
        (out_valid && out_cons_pc == $past(in_pc) && out_off == $past(in_off)));

    // R4: a load without a producer leaves a draining output empty
    a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_LOAD && !rd_hit && out_ready) |=> !out_valid);

endmodule

// File: tb/load_dep_tracker_bench.sv
module load_dep_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [1:0] OPL = 2'd1, OPS = 2'd2, OPW = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = '0;
    logic [31:0] in_pc = '0;
    logic [4:0]  in_dst = '0;
    logic [4:0]  in_base = '0;
    logic [15:0] in_off = '0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_prod_pc;
    logic [31:0] out_cons_pc;
    logic [15:0] out_off;

    int checks = 0;
    int errors = 0;
    bit hold_out = 1'b0;

    logic [31:0] q_prod[$];
    logic [31:0] q_cons[$];
    logic [15:0] q_off[$];
    string       q_tag[$];

    load_dep_tracker u_load_dep_tracker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_pc(in_pc), .in_dst(in_dst), .in_base(in_base),
        .in_off(in_off), .in_addr(in_addr), .out_valid(out_valid),
        .out_ready(out_ready), .out_prod_pc(out_prod_pc),
        .out_cons_pc(out_cons_pc), .out_off(out_off)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: sets out_ready, then pops and compares on every handshake
    initial begin
        forever begin
            @(negedge clk);
            out_ready = !hold_out;
            if (rst_n && out_valid && out_ready) begin
                if (q_tag.size() == 0) begin
                    check(1'b0, "R4", "unexpected record cons_pc", out_cons_pc, 32'h0);
                end else begin
                    logic [31:0] ep, ec;
                    logic [15:0] eo;
                    string t;
                    ep = q_prod.pop_front();
                    ec = q_cons.pop_front();
                    eo = q_off.pop_front();
                    t  = q_tag.pop_front();
                    check(out_prod_pc == ep, t, "producer pc", out_prod_pc, ep);
                    check(out_cons_pc == ec, t, "consumer pc", out_cons_pc, ec);
                    check(out_off == eo, t, "offset", {16'h0, out_off}, {16'h0, eo});
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "all", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    task automatic send(input logic [1:0] op, input logic [31:0] pc, input logic [4:0] dst,
                        input logic [4:0] base, input logic [15:0] off, input logic [31:0] addr);
        @(negedge clk);
        #1;
        in_op = op; in_pc = pc; in_dst = dst; in_base = base;
        in_off = off; in_addr = addr; in_valid = 1'b1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic ld(input logic [31:0] pc, input logic [4:0] dst, input logic [4:0] base,
                      input logic [15:0] off, input logic [31:0] addr,
                      input bit dep, input logic [31:0] prod, input string tag);
        if (dep) begin
            q_prod.push_back(prod);
            q_cons.push_back(pc);
            q_off.push_back(off);
            q_tag.push_back(tag);
        end
        send(OPL, pc, dst, base, off, addr);
    endtask

    task automatic idle_drain();
        @(negedge clk);
        #1;
        in_valid = 1'b0;
        while (q_tag.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(out_valid == 1'b0, "R1", "out_valid after reset", {31'h0, out_valid}, 32'h0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", {31'h0, in_ready}, 32'h1);
    endtask

    initial begin
        do_reset();

        // R1/R4: empty tables; R2/R3: chain with a self-based load
        ld(32'h118, 5'd16, 5'd16, 16'd8, 32'h1008, 1'b0, 32'h0, "R1");
        ld(32'h100, 5'd10, 5'd16, 16'd0, 32'h1000, 1'b1, 32'h118, "R2");
        ld(32'h104, 5'd4, 5'd16, 16'd4, 32'h1004, 1'b1, 32'h118, "R2");
        ld(32'h118, 5'd16, 5'd16, 16'd8, 32'h1008, 1'b1, 32'h118, "R3");
        ld(32'h118, 5'd16, 5'd16, 16'd8, 32'h2508, 1'b1, 32'h118, "R3");
        ld(32'h100, 5'd10, 5'd16, 16'd0, 32'h2500, 1'b1, 32'h118, "R3");
        // R11: opcode 0 does nothing
        send(2'd0, 32'h120, 5'd16, 5'd16, 16'd0, 32'h0);
        ld(32'h104, 5'd4, 5'd16, 16'd4, 32'h2504, 1'b1, 32'h118, "R11");

        // R5: register 0
        ld(32'h200, 5'd0, 5'd3, 16'd0, 32'h2200, 1'b0, 32'h0, "R5");
        ld(32'h204, 5'd9, 5'd0, 16'd4, 32'h2204, 1'b0, 32'h0, "R5");

        // R6: another write class clears the producer of register 16
        send(OPW, 32'h208, 5'd16, 5'd0, 16'd0, 32'h0);
        ld(32'h100, 5'd10, 5'd16, 16'd0, 32'h2300, 1'b0, 32'h0, "R6");

        // R10: fifty unrelated loads between producer and consumer
        ld(32'h300, 5'd20, 5'd1, 16'd0, 32'h2400, 1'b0, 32'h0, "R10");
        for (int i = 0; i < 50; i++) begin
            ld(32'h400 + 32'(i * 4), 5'(21 + (i % 8)), 5'd1, 16'd0,
               32'h3000 + 32'(i * 4), 1'b0, 32'h0, "R10");
        end
        ld(32'h500, 5'd2, 5'd20, 16'd12, 32'h2410, 1'b1, 32'h300, "R10");

        // R7: spill through memory and reload
        ld(32'h600, 5'd5, 5'd1, 16'd0, 32'h2600, 1'b0, 32'h0, "R7");
        send(OPS, 32'h604, 5'd5, 5'd29, 16'd0, 32'h7ff0);
        send(OPW, 32'h606, 5'd5, 5'd0, 16'd0, 32'h0);
        ld(32'h608, 5'd6, 5'd29, 16'd0, 32'h7ff0, 1'b0, 32'h0, "R7");
        ld(32'h60c, 5'd7, 5'd6, 16'd8, 32'h2700, 1'b1, 32'h600, "R7");

        // R8: store without producer clears the spill entry
        send(OPS, 32'h610, 5'd30, 5'd29, 16'd0, 32'h7ff0);
        ld(32'h614, 5'd6, 5'd29, 16'd0, 32'h7ff0, 1'b0, 32'h0, "R8");
        ld(32'h618, 5'd7, 5'd6, 16'd4, 32'h2800, 1'b1, 32'h614, "R8");
        idle_drain();

        // R11: blocked output, back-to-back dependent loads
        ld(32'h700, 5'd11, 5'd1, 16'd0, 32'h2900, 1'b0, 32'h0, "R11");
        hold_out = 1'b1;
        fork
            begin
                ld(32'h704, 5'd12, 5'd11, 16'd0, 32'h2a00, 1'b1, 32'h700, "R11");
                ld(32'h708, 5'd13, 5'd11, 16'd4, 32'h2a04, 1'b1, 32'h700, "R11");
            end
            begin
                repeat (6) @(negedge clk);
                #2;
                check(out_valid == 1'b1, "R11", "held valid", {31'h0, out_valid}, 32'h1);
                check(in_ready == 1'b0, "R11", "stalled input", {31'h0, in_ready}, 32'h0);
                check(out_cons_pc == 32'h704, "R11", "held record", out_cons_pc, 32'h704);
                hold_out = 1'b0;
            end
        join
        idle_drain();

        // R9: round-robin replacement in a fresh spill table
        do_reset();
        ld(32'h800, 5'd5, 5'd1, 16'd0, 32'h50, 1'b0, 32'h0, "R9");
        for (int i = 0; i < 17; i++) begin
            send(OPS, 32'h900 + 32'(i * 4), 5'd5, 5'd29, 16'd0, 32'h1000 + 32'(i * 16));
        end
        send(OPS, 32'h950, 5'd5, 5'd29, 16'd0, 32'h1010);
        ld(32'ha00, 5'd7, 5'd1, 16'd0, 32'h1000, 1'b0, 32'h0, "R9");
        ld(32'ha04, 5'd8, 5'd1, 16'd0, 32'h1010, 1'b0, 32'h0, "R9");
        ld(32'ha08, 5'd9, 5'd7, 16'd0, 32'h3000, 1'b1, 32'ha00, "R9");
        ld(32'ha0c, 5'd10, 5'd8, 16'd0, 32'h3004, 1'b1, 32'h800, "R9");
        idle_drain();

        check(q_tag.size() == 0, "R11", "records outstanding", 32'(q_tag.size()), 32'h0);
        finish_run();
    end

endmodule